// File: doc/BRIEF.md
# Vector Control and Status Register File

This block holds the control and status state of a vector unit and answers CSR reads and writes from the scalar core. It stores a sticky fixed-point saturation flag, a 2-bit fixed-point rounding mode, a start-element index, the active vector length and the vector type. It also answers a read-only byte-length register and a composite register that packs the rounding mode and the saturation flag into one word. The composite register has no storage of its own. It is a view onto the two separate registers.

The core reaches the block through a single-cycle port with address, write enable, write data and read data. A read returns the value for the presented address in the same cycle. A write takes effect at the next clock edge. The vector length and vector type cannot be changed by ordinary CSR writes. A separate configuration unit updates them through a private port, and that update also clears the start index. The datapath reports saturation events on a sticky-set input. The block drives its current rounding mode, saturation flag, start index, vector length and illegal-type flag to the datapath.

At reset the unit comes up in the illegal configuration: the type register reads with only its top bit set, and the vector length is zero.

Top module: `vec_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, the rounding mode, saturation flag, start index and vector length are 0, and the type register reads as a word with only bit XLEN-1 set (illegal flag high, `cur_vill`=1).
- R2: A write to the rounding-mode register (address 0x00A) keeps write-data bits [1:0] and drops all other bits. The encodings are 0 nearest-up, 1 nearest-even, 2 round-down, 3 round-to-odd.
- R3: A write to the start-index register (address 0x008) keeps only the bits under the mask VLEN-1, which is bits [6:0] at the default VLEN=128.
- R4: Ordinary CSR writes to the vector-length register (0xC20) or the vector-type register (0xC21) leave both unchanged.
- R5: The byte-length register (0xC22) always reads VLEN/8 (16 at the default), and writes to it have no effect.
- R6: A read of the composite register (0x00F) returns the saturation flag in bit 0, the rounding mode in bits [2:1], and zero in all other bits.
- R7: A write to the composite register sets the saturation flag from write-data bit 0 and the rounding mode from bits [2:1], both at the same clock edge.
- R8: The saturation-set input makes the flag 1 at the next edge. The flag then stays 1 until a CSR write clears it. When a set and a clearing write arrive in the same cycle, the set wins.
- R9: A configuration-port strobe loads the vector length and the full type word, and clears the start index. It takes priority over a CSR write to the start index in the same cycle.
- R10: An address outside the seven listed ones reads as 0, and writing to it changes no register.
- R11: Read data reflects the register state before the clock edge. A written value becomes visible in the cycle after the write.
- R12: A write to the saturation register (0x009) keeps write-data bit 0 and drops all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_addr, same cycle |
| sat_set | input | 1 | Datapath saturation event, sets the sticky flag |
| cfg_we | input | 1 | Configuration-unit update strobe |
| cfg_vl | input | VL_W | New vector length |
| cfg_vtype | input | XLEN | New vector-type word |
| cur_rm | output | 2 | Current rounding mode |
| cur_sat | output | 1 | Current saturation flag |
| cur_start | output | START_W | Current start-element index |
| cur_vl | output | VL_W | Current vector length |
| cur_vill | output | 1 | Top bit of the type register (illegal configuration) |

## Verification
The bench first reads every register right after reset. It then writes each register with all-ones and with alternating patterns, so that a mask that is too wide or too narrow shows up as stray bits. Writes to the composite register and to the separate registers are interleaved, which separates correct aliasing from a composite copy that drifts out of step. Same-cycle collisions (a saturation event against a clearing write, a configuration update against a start-index write) show which source wins. A long run with random addresses, including unlisted ones, mixes all of these against the reference model on every clock.

// File: rtl/vcsr_pkg.sv
// Package: addresses, read-select indices and the rounding-mode encoding
// shared by the vector control register file and its bench.
package vcsr_pkg;

    localparam int ADDR_W = 12;
    localparam int NSEL   = 7;

    // Read/write select index of each register
    localparam int S_START = 0;
    localparam int S_SAT   = 1;
    localparam int S_RM    = 2;
    localparam int S_CMP   = 3;
    localparam int S_VL    = 4;
    localparam int S_VTYPE = 5;
    localparam int S_VLENB = 6;

    localparam logic [ADDR_W-1:0] A_START = 12'h008;
    localparam logic [ADDR_W-1:0] A_SAT   = 12'h009;
    localparam logic [ADDR_W-1:0] A_RM    = 12'h00A;
    localparam logic [ADDR_W-1:0] A_CMP   = 12'h00F;
    localparam logic [ADDR_W-1:0] A_VL    = 12'hC20;
    localparam logic [ADDR_W-1:0] A_VTYPE = 12'hC21;
    localparam logic [ADDR_W-1:0] A_VLENB = 12'hC22;

    // Bit position of the rounding mode inside the composite register
    localparam int CMP_RM_LSB = 1;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/vcsr_decode.sv
// Module: vcsr_decode
// Turns a CSR address into a one-hot select, with one bit per register.
// Assumes that the listed addresses are distinct. An unlisted address
// gives an all-zero select.
module vcsr_decode
    import vcsr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);

    localparam logic [ADDR_W-1:0] ADDR_TBL [NSEL] = '{
        A_START, A_SAT, A_RM, A_CMP, A_VL, A_VTYPE, A_VLENB
    };

    // One comparator per register address
    for (genvar i = 0; i < NSEL; i++) begin : g_cmp
        assign sel[i] = (addr == ADDR_TBL[i]);
    end

endmodule

// File: rtl/vcsr_fixpt.sv
// Module: vcsr_fixpt
// Stores the sticky saturation flag and the rounding mode. The composite
// register writes both fields at once. A datapath saturation event takes
// priority over a same-cycle CSR write to the flag.
module vcsr_fixpt
    import vcsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_sat,
    input  logic      wr_rm,
    input  logic      wr_cmp,
    input  logic [2:0] wdata_lo,
    input  logic      sat_set,
    output logic      sat_q,
    output rnd_mode_e rm_q
);

    logic      sat_d;
    rnd_mode_e rm_d;

    // Next value of the saturation flag: CSR write first, then the sticky set on top
    always_comb begin
        sat_d = sat_q;
        if (wr_sat || wr_cmp) begin
            sat_d = wdata_lo[0];
        end
        if (sat_set) begin
            sat_d = 1'b1;
        end
    end

    // Next rounding mode, from the plain register or from the composite field
    always_comb begin
        rm_d = rm_q;
        if (wr_rm) begin
            rm_d = rnd_mode_e'(wdata_lo[1:0]);
        end else if (wr_cmp) begin
            rm_d = rnd_mode_e'(wdata_lo[CMP_RM_LSB +: 2]);
        end
    end

    // State update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_q <= 1'b0;
            rm_q  <= RM_NEAR_UP;
        end else begin
            sat_q <= sat_d;
            rm_q  <= rm_d;
        end
    end

    // R8: a saturation event always leaves the flag set
    a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sat_set |=> sat_q);

    // R8: the flag cannot fall without a CSR write
    a_r8_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !wr_sat && !wr_cmp) |=> sat_q);

    // R2: the rounding mode changes only on a write
    a_r2_rm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rm && !wr_cmp) |=> $stable(rm_q));

endmodule

// File: rtl/vcsr_cfg.sv
// Module: vcsr_cfg
// Stores the start index, the vector length and the vector type. The
// length and type change only through the configuration strobe, which also
// clears the start index. Reset applies the illegal configuration: the type
// word has only its top bit set and the length is zero.
module vcsr_cfg #(
    parameter int XLEN    = 32,
    parameter int START_W = 7,
    parameter int VL_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_start,
    input  logic [START_W-1:0] wdata_start,
    input  logic               cfg_we,
    input  logic [VL_W-1:0]    cfg_vl,
    input  logic [XLEN-1:0]    cfg_vtype,
    output logic [START_W-1:0] start_q,
    output logic [VL_W-1:0]    vl_q,
    output logic [XLEN-1:0]    vtype_q
);

    localparam logic [XLEN-1:0] VTYPE_ILLEGAL = {1'b1, {(XLEN-1){1'b0}}};

    // Start index: the configuration clear wins over a CSR write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (cfg_we) begin
            start_q <= '0;
        end else if (wr_start) begin
            start_q <= wdata_start;
        end
    end

    // Length and type, loaded only by the configuration unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            vtype_q <= VTYPE_ILLEGAL;
        end else if (cfg_we) begin
            vl_q    <= cfg_vl;
            vtype_q <= cfg_vtype;
        end
    end

    // R9: a configuration update clears the start index
    a_r9_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (start_q == '0));

    // R4: without a configuration strobe the length and type hold
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(vl_q) && $stable(vtype_q)));

endmodule

// File: rtl/vec_ctrl_regs.sv
// Module: vec_ctrl_regs
// Top of the vector control register file. It decodes the CSR address,
// routes write strobes to the storage modules and builds the same-cycle
// read data. Assumes VLEN is a power of two and at least 8.
module vec_ctrl_regs
    import vcsr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLEN = 128,
    parameter int START_W = $clog2(VLEN),
    parameter int VL_W    = $clog2(VLEN) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic               csr_we,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic               sat_set,
    input  logic               cfg_we,
    input  logic [VL_W-1:0]    cfg_vl,
    input  logic [XLEN-1:0]    cfg_vtype,
    output logic [1:0]         cur_rm,
    output logic               cur_sat,
    output logic [START_W-1:0] cur_start,
    output logic [VL_W-1:0]    cur_vl,
    output logic               cur_vill
);

    localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

    logic [NSEL-1:0]    sel;
    logic [NSEL-1:0]    wr;
    logic               sat_q;
    rnd_mode_e          rm_q;
    logic [START_W-1:0] start_q;
    logic [VL_W-1:0]    vl_q;
    logic [XLEN-1:0]    vtype_q;
    logic [XLEN-1:0]    fld [NSEL];

    vcsr_decode u_decode (
        .addr (csr_addr),
        .sel  (sel)
    );

    // Write strobes: a select gated by the write enable
    assign wr = sel & {NSEL{csr_we}};

    vcsr_fixpt u_fixpt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sat   (wr[S_SAT]),
        .wr_rm    (wr[S_RM]),
        .wr_cmp   (wr[S_CMP]),
        .wdata_lo (csr_wdata[2:0]),
        .sat_set  (sat_set),
        .sat_q    (sat_q),
        .rm_q     (rm_q)
    );

    vcsr_cfg #(
        .XLEN    (XLEN),
        .START_W (START_W),
        .VL_W    (VL_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start    (wr[S_START]),
        .wdata_start (csr_wdata[START_W-1:0]),
        .cfg_we      (cfg_we),
        .cfg_vl      (cfg_vl),
        .cfg_vtype   (cfg_vtype),
        .start_q     (start_q),
        .vl_q        (vl_q),
        .vtype_q     (vtype_q)
    );

    // Read value of each register, zero-extended to XLEN
    always_comb begin
        fld[S_START] = XLEN'(start_q);
        fld[S_SAT]   = XLEN'(sat_q);
        fld[S_RM]    = XLEN'(rm_q);
        fld[S_CMP]   = XLEN'({rm_q, sat_q});
        fld[S_VL]    = XLEN'(vl_q);
        fld[S_VTYPE] = vtype_q;
        fld[S_VLENB] = VLENB_VAL;
    end

    // AND-OR read multiplexer; an unlisted address gives zero
    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NSEL; i++) begin
            csr_rdata = csr_rdata | (fld[i] & {XLEN{sel[i]}});
        end
    end

    // Current state driven to the datapath
    assign cur_rm    = rm_q;
    assign cur_sat   = sat_q;
    assign cur_start = start_q;
    assign cur_vl    = vl_q;
    assign cur_vill  = vtype_q[XLEN-1];

    // R6: the composite read agrees with the separate flag and mode outputs
    a_r6_cmp_view: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_CMP) |-> (csr_rdata[0] == cur_sat &&
                                 csr_rdata[2:1] == cur_rm &&
                                 csr_rdata[XLEN-1:3] == '0));

    // R5: the byte-length register reads constant
    a_r5_vlenb_const: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_VLENB) |-> (csr_rdata == VLENB_VAL));

endmodule

// File: tb/vec_ctrl_regs_bench.sv
// Bench: a behavioural reference model compared against the outputs on every clock.
module vec_ctrl_regs_bench;
    import vcsr_pkg::*;

    localparam int XLEN = 32;
    localparam int VLEN = 128;
    localparam int SW   = $clog2(VLEN);
    localparam int VW   = $clog2(VLEN) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            sat_set = 1'b0;
    logic            cfg_we = 1'b0;
    logic [VW-1:0]   cfg_vl = '0;
    logic [XLEN-1:0] cfg_vtype = '0;
    logic [1:0]      cur_rm;
    logic            cur_sat;
    logic [SW-1:0]   cur_start;
    logic [VW-1:0]   cur_vl;
    logic            cur_vill;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    int unsigned m_sat, m_rm, m_start, m_vl, m_vtype;

    always #10 clk = ~clk;

    vec_ctrl_regs #(.XLEN(XLEN), .VLEN(VLEN)) u_vec_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .sat_set(sat_set),
        .cfg_we(cfg_we), .cfg_vl(cfg_vl), .cfg_vtype(cfg_vtype),
        .cur_rm(cur_rm), .cur_sat(cur_sat), .cur_start(cur_start),
        .cur_vl(cur_vl), .cur_vill(cur_vill)
    );

    function automatic int unsigned model_read(input logic [11:0] a);
        case (a)
            A_START: return m_start;
            A_SAT:   return m_sat;
            A_RM:    return m_rm;
            A_CMP:   return (m_rm << 1) | m_sat;
            A_VL:    return m_vl;
            A_VTYPE: return m_vtype;
            A_VLENB: return VLEN / 8;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare before the edge, then advance the model
    task automatic step(input logic [11:0] a, input bit we, input int unsigned wd,
                        input bit ss, input bit cw, input int unsigned cvl,
                        input int unsigned cvt, input string req);
        @(negedge clk);
        csr_addr = a; csr_we = we; csr_wdata = wd; sat_set = ss;
        cfg_we = cw; cfg_vl = VW'(cvl); cfg_vtype = cvt;
        #1;
        check(req, "rdata", csr_rdata, model_read(a));
        check(req, "cur_rm", cur_rm, m_rm);
        check(req, "cur_sat", cur_sat, m_sat);
        check(req, "cur_start", cur_start, m_start);
        check(req, "cur_vl", cur_vl, m_vl);
        check(req, "cur_vill", cur_vill, m_vtype >> 31);
        @(posedge clk);
        if (we && (a == A_SAT || a == A_CMP)) m_sat = wd & 1;
        if (ss) m_sat = 1;
        if (we && a == A_RM) m_rm = wd & 3;
        else if (we && a == A_CMP) m_rm = (wd >> 1) & 3;
        if (cw) begin
            m_start = 0; m_vl = cvl % (2 * VLEN); m_vtype = cvt;
        end else if (we && a == A_START) begin
            m_start = wd % VLEN;
        end
    endtask

    task automatic idle_read(input logic [11:0] a, input string req);
        step(a, 1'b0, 0, 1'b0, 1'b0, 0, 0, req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        m_sat = 0; m_rm = 0; m_start = 0; m_vl = 0; m_vtype = 32'h8000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state on every address
        idle_read(A_START, "R1"); idle_read(A_SAT, "R1"); idle_read(A_RM, "R1");
        idle_read(A_VL, "R1");    idle_read(A_VTYPE, "R1"); idle_read(A_CMP, "R1");
        // R2 rounding mode masking, each encoding
        step(A_RM, 1, 32'hFFFF_FFFD, 0, 0, 0, 0, "R2"); idle_read(A_RM, "R2");
        step(A_RM, 1, 32'h0000_0002, 0, 0, 0, 0, "R2"); idle_read(A_RM, "R2");
        step(A_RM, 1, 32'hAAAA_AAAB, 0, 0, 0, 0, "R2"); idle_read(A_RM, "R2");
        // R12 saturation register keeps bit 0 only
        step(A_SAT, 1, 32'hFFFF_FFFE, 0, 0, 0, 0, "R12"); idle_read(A_SAT, "R12");
        step(A_SAT, 1, 32'h0000_0003, 0, 0, 0, 0, "R12"); idle_read(A_SAT, "R12");
        // R3 start index mask
        step(A_START, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3"); idle_read(A_START, "R3");
        step(A_START, 1, 32'h5555_0155, 0, 0, 0, 0, "R3"); idle_read(A_START, "R3");
        // R4 length and type ignore CSR writes
        step(A_VL, 1, 32'h0000_0011, 0, 0, 0, 0, "R4");  idle_read(A_VL, "R4");
        step(A_VTYPE, 1, 32'h0000_0012, 0, 0, 0, 0, "R4"); idle_read(A_VTYPE, "R4");
        // R5 byte length is read-only
        step(A_VLENB, 1, 32'h0000_00FF, 0, 0, 0, 0, "R5"); idle_read(A_VLENB, "R5");
        // R7 / R6 composite scatter and gather
        step(A_CMP, 1, 32'hFFFF_FFF4, 0, 0, 0, 0, "R7"); idle_read(A_CMP, "R6");
        step(A_CMP, 1, 32'h0000_0003, 0, 0, 0, 0, "R7"); idle_read(A_CMP, "R6");
        idle_read(A_RM, "R7"); idle_read(A_SAT, "R7");
        // R8 sticky set beats a same-cycle clear
        step(A_SAT, 1, 0, 0, 0, 0, 0, "R8");
        step(A_START, 0, 0, 1, 0, 0, 0, "R8"); idle_read(A_SAT, "R8");
        step(A_SAT, 1, 0, 1, 0, 0, 0, "R8"); idle_read(A_SAT, "R8");
        step(A_CMP, 1, 0, 1, 0, 0, 0, "R8"); idle_read(A_CMP, "R8");
        step(A_SAT, 1, 0, 0, 0, 0, 0, "R8"); idle_read(A_SAT, "R8");
        // R9 configuration update wins over a start write
        step(A_START, 1, 32'h0000_0021, 0, 0, 0, 0, "R9");
        step(A_START, 1, 32'h0000_0044, 0, 1, 128, 32'h0000_00D3, "R9");
        idle_read(A_START, "R9"); idle_read(A_VL, "R9"); idle_read(A_VTYPE, "R9");
        // R10 unlisted address
        step(12'h123, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R10"); idle_read(12'h123, "R10");
        idle_read(A_CMP, "R10"); idle_read(A_START, "R10");
        // R11 mixed random traffic, compared cycle by cycle
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            case ($urandom % 9)
                0: a = A_START; 1: a = A_SAT; 2: a = A_RM; 3: a = A_CMP;
                4: a = A_VL; 5: a = A_VTYPE; 6: a = A_VLENB; 7: a = 12'h00B;
                default: a = 12'hC23;
            endcase
            step(a, ($urandom % 2) == 1, $urandom, ($urandom % 6) == 0,
                 ($urandom % 8) == 0, $urandom % 129, $urandom, "R11");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule